// File: doc/BRIEF.md
# Frame Alignment Offset Meter

This block measures how far a chosen frame-evaluation signal lags the system's reference frame pulse. Both signals are sampled on the system clock, and only their falling edges matter. Software first sets a select field to pick one of 24 evaluation inputs. It then raises a start bit. Once the next reference falling edge opens a measurement frame, the block counts clock cycles until the first falling edge of the selected input. When the frame closes, the count appears on a 10-bit offset output and a completion flag goes high.

A measurement runs once per rising edge of the start bit. Before it can be armed again, the start bit must be brought low and held there across a full frame. Dropping the start bit clears the completion flag and cancels any measurement still in progress. The last valid offset stays on the output until a later measurement completes. A missing evaluation edge, or one that comes later than the counter can represent, reads back as all ones.

Top module: `frame_offset_meter`

## Requirements
- R1: With `eval_sel` equal to k (0 to 23), only `eval_in[k]` is measured; edges on the other 23 inputs have no effect on the result. Select values 24 to 31 pick no input, so the measurement reports no edge.
- R2: The offset equals the number of clock cycles between the clock at which the reference falling edge is sampled and the clock at which the selected input's falling edge is sampled. If both edges are sampled at the same clock, the offset is 0.
- R3: Only the first falling edge of the selected input in the measurement frame is counted. Edges that occur before the measurement frame opens are ignored.
- R4: A rising edge on `start` arms the unit. The measurement frame is the one that begins at the next reference falling edge and ends at the reference falling edge after that.
- R5: `done` goes high, and `offset` is updated, on the clock that samples the reference falling edge closing the measurement frame. Both are visible one clock cycle after the reference pulse goes low.
- R6: A rising edge on `start` arms the unit only if `start` has been low across at least two reference falling edges, which spans at least one full frame. Otherwise the rising edge is ignored, and `done` and `offset` stay unchanged.
- R7: If no falling edge of the selected input is seen in the measurement frame, `offset` reads 1023 and `done` is still raised.
- R8: If the selected input's edge comes 1023 or more cycles after the reference edge, `offset` saturates at 1023.
- R9: While `start` is low, `done` is cleared on the next clock. Dropping `start` during a measurement cancels it: `done` is not raised and `offset` is not changed.
- R10: After reset, `done` is 0 and `offset` is 0. `offset` changes only at completion and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_fp | input | 1 | Reference frame pulse; its falling edge marks the start of each frame |
| eval_in | input | 24 | Frame-evaluation inputs |
| eval_sel | input | 5 | Index of the evaluation input to measure |
| start | input | 1 | Arms a measurement on its rising edge |
| offset | output | 10 | Latched offset in clock cycles |
| done | output | 1 | Completion flag |

## Verification
Measurements are taken with the selected input falling at several distinct delays. These include a delay of zero, where both edges coincide, and delays on either side of the 1023 limit. This separates exact counting from off-by-one errors and from saturation. Other stimuli pull every non-selected input low earlier than the selected one, produce a second selected edge later in the frame, and place a selected edge inside the arming frame. These show whether the result comes from the right input and from the first edge inside the measurement frame only. A missing edge, an out-of-range select value, an early re-arm after only one low frame edge, and a start bit dropped mid-frame each show whether the completion flag and the held offset react only to legitimate completions.

// File: rtl/frame_offset_meter.sv
module frame_offset_meter #(
  parameter int N_EVAL     = 24,
  parameter int SEL_W      = 5,
  parameter int CNT_W      = 10,
  parameter int QUAL_EDGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_fp,
  input  logic [N_EVAL-1:0] eval_in,
  input  logic [SEL_W-1:0]  eval_sel,
  input  logic              start,
  output logic [CNT_W-1:0]  offset,
  output logic              done
);
  localparam int QW = $clog2(QUAL_EDGES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [SEL_W-1:0] SEL_LAST = SEL_W'(N_EVAL - 1);
  localparam logic [QW-1:0] QUAL_FULL = QW'(QUAL_EDGES);

  typedef enum logic [1:0] {IDLE, PEND, MEAS} state_t;

  state_t           state;
  logic             ref_q, ev_q, start_q, found;
  logic [QW-1:0]    qual;
  logic [CNT_W-1:0] cnt, cap;

  wire ev_now     = (eval_sel <= SEL_LAST) ? eval_in[eval_sel] : 1'b1;
  wire ref_fall   = ref_q & ~ref_fp;
  wire ev_fall    = ev_q & ~ev_now;
  wire start_rise = start & ~start_q;
  wire armed_ok   = (qual == QUAL_FULL);

  wire [CNT_W-1:0] cnt_cur = ref_fall ? '0 : cnt;
  wire [CNT_W-1:0] cnt_nxt = (cnt_cur == CNT_MAX) ? CNT_MAX : cnt_cur + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q   <= 1'b1;
      ev_q    <= 1'b1;
      start_q <= 1'b0;
      cnt     <= '0;
      qual    <= '0;
    end else begin
      ref_q   <= ref_fp;
      ev_q    <= ev_now;
      start_q <= start;
      cnt     <= cnt_nxt;
      if (start)
        qual <= '0;
      else if (ref_fall && !armed_ok)
        qual <= qual + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= IDLE;
      found  <= 1'b0;
      cap    <= '0;
      offset <= '0;
      done   <= 1'b0;
    end else if (!start) begin
      state <= IDLE;
      done  <= 1'b0;
    end else begin
      case (state)
        IDLE: if (start_rise && armed_ok) state <= PEND;
        PEND: if (ref_fall) begin
          state <= MEAS;
          found <= ev_fall;
          cap   <= '0;
        end
        MEAS: if (ref_fall) begin
          offset <= found ? cap : CNT_MAX;
          done   <= 1'b1;
          state  <= IDLE;
        end else if (ev_fall && !found) begin
          cap   <= cnt_cur;
          found <= 1'b1;
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/frame_offset_meter_chk.sv
module frame_offset_meter_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_fp,
  input logic             start,
  input logic [CNT_W-1:0] offset,
  input logic             done
);
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done); // R9

  AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start)); // R9

  AST_DONE_ON_REF_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (!$past(ref_fp) && $past(ref_fp, 2))); // R5

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> done); // R5

  AST_OFFSET_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(done) |-> $stable(offset)); // R10
endmodule

bind frame_offset_meter frame_offset_meter_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ref_fp(ref_fp), .start(start),
  .offset(offset), .done(done)
);

// File: tb/frame_offset_meter_tb_top.sv
`timescale 1ns/1ps
module frame_offset_meter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_fp = 1'b1;
  logic [23:0] eval_in = '1;
  logic [4:0]  eval_sel = '0;
  logic        start = 1'b0;
  logic [9:0]  offset;
  logic        done;

  int n_chk = 0;
  int n_fail = 0;
  logic [9:0] last_off = '0;

  always #2 clk = ~clk;

  frame_offset_meter dut_i (
    .clk(clk), .rst_n(rst_n), .ref_fp(ref_fp), .eval_in(eval_in),
    .eval_sel(eval_sel), .start(start), .offset(offset), .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One frame: reference low at cycle 0. The selected bit falls at ev_a and ev_b,
  // the other bits fall at oth. start is set to st_val at cycle st_at.
  task automatic run_frame(input int len, input int bit_i, input int ev_a, input int ev_b,
                           input int oth, input int st_at, input logic st_val,
                           input bit chk, input logic exp_done, input int exp_off,
                           input string req);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (chk && i == 1) begin
        check(req, int'(done), int'(exp_done));
        check(req, int'(offset), exp_off);
      end
      ref_fp = (i != 0);
      eval_in = '1;
      if (oth >= 0 && i >= oth && i < oth + 2) eval_in = '0;
      if (bit_i < 24)
        eval_in[bit_i] = !((ev_a >= 0 && i >= ev_a && i < ev_a + 2) ||
                           (ev_b >= 0 && i >= ev_b && i < ev_b + 2));
      if (i == st_at) start = st_val;
    end
  endtask

  task automatic measure(input int dsel, input int bit_i, input int ev_a, input int ev_b,
                         input int oth, input int len, input int exp_off, input string req);
    @(negedge clk);
    start = 1'b0;
    eval_sel = 5'(dsel);
    run_frame(len, bit_i, -1, -1, -1, -1, 1'b0, 1'b0, 1'b0, 0, req);
    run_frame(len, bit_i, -1, -1, -1, -1, 1'b0, 1'b0, 1'b0, 0, req);
    // Arming frame: a selected edge after the start rise must be ignored (R3)
    run_frame(len, bit_i, len/2 + 2, -1, -1, len/2, 1'b1, 1'b0, 1'b0, 0, req);
    run_frame(len, bit_i, ev_a, ev_b, oth, -1, 1'b1, 1'b1, 1'b0, last_off, req);
    run_frame(len, bit_i, -1, -1, -1, -1, 1'b1, 1'b1, 1'b1, exp_off, req);
    last_off = 10'(exp_off);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check("R9 done cleared", int'(done), 0);
    check("R10 offset held", int'(offset), exp_off);
  endtask

  task automatic t_rearm_too_soon();
    @(negedge clk);
    start = 1'b1;
    // start low across one reference edge only
    run_frame(20, 2, -1, -1, -1, 17, 1'b0, 1'b0, 1'b0, 0, "R6");
    run_frame(20, 2, -1, -1, -1, 5, 1'b1, 1'b0, 1'b0, 0, "R6");
    run_frame(20, 2, 4, -1, -1, -1, 1'b1, 1'b1, 1'b0, last_off, "R6 no arm");
    run_frame(20, 2, -1, -1, -1, -1, 1'b1, 1'b1, 1'b0, last_off, "R6 no done");
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_abort();
    @(negedge clk);
    start = 1'b0;
    eval_sel = 5'd9;
    run_frame(20, 9, -1, -1, -1, -1, 1'b0, 1'b0, 1'b0, 0, "R9");
    run_frame(20, 9, -1, -1, -1, -1, 1'b0, 1'b0, 1'b0, 0, "R9");
    run_frame(20, 9, -1, -1, -1, 8, 1'b1, 1'b0, 1'b0, 0, "R9");
    run_frame(20, 9, 5, -1, -1, 10, 1'b0, 1'b0, 1'b0, 0, "R9");
    run_frame(20, 9, -1, -1, -1, -1, 1'b0, 1'b1, 1'b0, last_off, "R9 abort");
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset done", int'(done), 0);
    check("R10 reset offset", int'(offset), 0);
    measure(0, 0, 5, -1, -1, 40, 5, "R2 basic");
    measure(23, 23, 17, -1, 3, 40, 17, "R1 select 23 vs others");
    measure(7, 7, 0, -1, -1, 30, 0, "R2 coincident edges");
    measure(4, 4, 6, 20, -1, 30, 6, "R3 first edge");
    measure(11, 11, -1, -1, 2, 30, 1023, "R7 no edge");
    measure(25, 99, -1, -1, 4, 30, 1023, "R1 out-of-range select");
    measure(12, 12, 1022, -1, -1, 1100, 1022, "R8 just below limit");
    measure(13, 13, 1050, -1, -1, 1100, 1023, "R8 saturation");
    measure(1, 1, 9, -1, -1, 24, 9, "R4 arm");
    t_rearm_too_soon();
    t_abort();
    measure(20, 20, 3, -1, -1, 16, 3, "R5 after abort");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule